// File: doc/BRIEF.md
# Scalar Double-Precision Predicate Compare Unit

This block compares two IEEE-754 double-precision values under a 3-bit predicate code. The first operand is the low 64 bits of a 128-bit destination value. The second operand is a separate 64-bit input. The block returns the destination with its low 64 bits replaced by a mask. The mask is all ones when the chosen relation holds and all zeros when it does not. The upper 64 bits are carried through unchanged. The eight predicates cover the plain relations, their negations, and the ordered and unordered tests. A negated relation is true when either operand is NaN.

There is no greater-than predicate. A caller gets greater-than by swapping the operands of a less-than or less-or-equal predicate. The block also reports no exception flags, and it treats both kinds of NaN alike, as unordered.

A small two-state output machine drives the valid flag:
- `ST_IDLE` moves to `ST_EMIT` on a cycle with `in_valid` high.
- `ST_EMIT` moves back to `ST_IDLE` when `in_valid` is low.
- `ST_EMIT` stays in `ST_EMIT` when another strobe arrives.
- Reset forces `ST_IDLE` from either state.

The result register loads only on strobe cycles and holds its value otherwise.

Top module: `fp64_pred_cmp`

## Requirements
- R1: The predicate code `pred` selects the relation: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered.
- R2: Bits [63:0] of `res_out` are all ones when the selected relation is true and all zeros when it is false.
- R3: Bits [127:64] of `res_out` equal bits [127:64] of the `dst_in` captured with the strobe.
- R4: The first operand is `dst_in[63:0]`. Changing `dst_in[127:64]` never changes the mask.
- R5: An operand is NaN when bits [62:52] are all ones and bits [51:0] are nonzero. If either operand is NaN, predicates 0, 1, 2 and 7 give zeros and predicates 3, 4, 5 and 6 give ones.
- R6: Positive zero (0x0000000000000000) and negative zero (0x8000000000000000) compare equal, and neither is less than the other.
- R7: Ordered operands follow numeric order:
  - a negative value is below a positive value;
  - between two negatives, the larger magnitude is the smaller value;
  - infinities lie at the extremes.
- R8: Greater-than is obtained by swapping the operands: predicate 1 with the first operand b and the second operand a yields ones exactly when a > b.
- R9: `res_valid` and `res_out` are updated on the clock edge that samples `in_valid` high. `res_valid` is high for exactly the cycles following strobe cycles.
- R10: Synchronous active-high `rst` clears `res_valid` and `res_out`, and it overrides a strobe in the same cycle.
- R11: While `in_valid` is low, `res_out` holds its last value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: compare this cycle's inputs |
| dst_in | input | 128 | Destination value; low half is the first operand |
| src_in | input | 64 | Second operand |
| pred | input | 3 | Predicate code |
| res_out | output | 128 | Upper destination half with the mask in the low half |
| res_valid | output | 1 | Result valid, one cycle after the strobe |

## Verification
The bench targets the following operand pairs. For each, it states what a faulty design would produce:

- **Signed zeros.** A design that compared raw bits would call -0 less than +0, or call the two unequal.
- **NaN operands, quiet and signalling, with every predicate.** A design that dropped the unordered override would return ones for the positive relations, or zeros for the negated ones.
- **Pairs of negative numbers.** Treating sign-magnitude encodings as two's complement reverses their order.
- **Infinities against each other and against finite values.** An exponent of all ones is easy to misread as NaN when the mantissa test is missing.
- **Operands swapped under less-than.** This confirms that greater-than needs no separate code.
- **Garbage on the data inputs between strobes, changed upper destination bits, and a reset in the same cycle as a strobe.** These expose a result register that loads without a strobe, a mask that depends on the upper half, and a reset that loses priority.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NEQ   = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } pred_e;

    typedef struct packed {
        logic is_nan;
        logic is_zero;
        logic neg;
    } opnd_cls_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic [DATA_W-1:0] opnd,
    output opnd_cls_t         cls,
    output logic [DATA_W-2:0] mag
);
    localparam int MAN_W = DATA_W - 1 - EXP_W;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    always_comb begin
        expo        = opnd[DATA_W-2 -: EXP_W];
        mant        = opnd[MAN_W-1:0];
        mag         = opnd[DATA_W-2:0];
        cls.neg     = opnd[DATA_W-1];
        cls.is_nan  = (&expo) && (|mant);
        cls.is_zero = ~(|mag);
    end

endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
    import fpcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  opnd_cls_t         a_cls,
    input  opnd_cls_t         b_cls,
    input  logic [DATA_W-2:0] a_mag,
    input  logic [DATA_W-2:0] b_mag,
    output logic              unord,
    output logic              eq,
    output logic              lt
);
    logic same_bits;
    logic both_zero;
    logic mag_lt;
    logic mag_gt;

    always_comb begin
        unord     = a_cls.is_nan | b_cls.is_nan;
        same_bits = (a_mag == b_mag) && (a_cls.neg == b_cls.neg);
        both_zero = a_cls.is_zero & b_cls.is_zero;
        mag_lt    = a_mag < b_mag;
        mag_gt    = a_mag > b_mag;
        eq        = ~unord & (same_bits | both_zero);
        if (unord || eq) begin
            lt = 1'b0;
        end else if (a_cls.neg != b_cls.neg) begin
            lt = a_cls.neg;
        end else if (a_cls.neg) begin
            lt = mag_gt;
        end else begin
            lt = mag_lt;
        end
    end

endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
    import fpcmp_pkg::*;
(
    input  logic [2:0] pred,
    input  logic       unord,
    input  logic       eq,
    input  logic       lt,
    output logic       hit
);
    pred_e code;

    always_comb begin
        code = pred_e'(pred);
        unique case (code)
            PR_EQ:    hit = eq;
            PR_LT:    hit = lt;
            PR_LE:    hit = lt | eq;
            PR_UNORD: hit = unord;
            PR_NEQ:   hit = ~eq;
            PR_NLT:   hit = ~lt;
            PR_NLE:   hit = ~(lt | eq);
            PR_ORD:   hit = ~unord;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fp64_pred_cmp.sv
module fp64_pred_cmp
    import fpcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2*DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0]   src_in,
    input  logic [2:0]          pred,
    output logic [2*DATA_W-1:0] res_out,
    output logic                res_valid
);
    localparam int DST_W = 2 * DATA_W;
    localparam int N_OP  = 2;

    logic [DATA_W-1:0] opnd   [N_OP];
    opnd_cls_t         cls    [N_OP];
    logic [DATA_W-2:0] mag    [N_OP];
    logic              unord;
    logic              eq;
    logic              lt;
    logic              hit;
    out_state_e        state_q;
    out_state_e        state_d;

    assign opnd[0] = dst_in[DATA_W-1:0];
    assign opnd[1] = src_in;

    for (genvar gi = 0; gi < N_OP; gi++) begin : g_cls
        fpcmp_classify #(
            .DATA_W (DATA_W),
            .EXP_W  (EXP_W)
        ) u_cls (
            .opnd (opnd[gi]),
            .cls  (cls[gi]),
            .mag  (mag[gi])
        );
    end

    fpcmp_relate #(
        .DATA_W (DATA_W)
    ) u_rel (
        .a_cls (cls[0]),
        .b_cls (cls[1]),
        .a_mag (mag[0]),
        .b_mag (mag[1]),
        .unord (unord),
        .eq    (eq),
        .lt    (lt)
    );

    fpcmp_select u_sel (
        .pred  (pred),
        .unord (unord),
        .eq    (eq),
        .lt    (lt),
        .hit   (hit)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out <= '0;
        end else if (in_valid) begin
            res_out <= {dst_in[DST_W-1:DATA_W], {DATA_W{hit}}};
        end
    end

    assign res_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/fp64_pred_cmp_chk.sv
module fp64_pred_cmp_chk #(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [2*DATA_W-1:0] dst_in,
    input logic [DATA_W-1:0]   src_in,
    input logic [2:0]          pred,
    input logic [2*DATA_W-1:0] res_out,
    input logic                res_valid
);
    localparam int MAN_W = DATA_W - 1 - EXP_W;

    logic src_nan;
    logic a_zero;
    logic b_zero;

    assign src_nan = (&src_in[DATA_W-2 -: EXP_W]) && (|src_in[MAN_W-1:0]);
    assign a_zero  = ~(|dst_in[DATA_W-2:0]);
    assign b_zero  = ~(|src_in[DATA_W-2:0]);

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    p_valid_drops_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    p_upper_pass_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_out[2*DATA_W-1:DATA_W] == $past(dst_in[2*DATA_W-1:DATA_W]));

    p_full_mask_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((&res_out[DATA_W-1:0]) || !(|res_out[DATA_W-1:0])));

    p_nan_unord_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_nan && pred == 3'd3) |=> (&res_out[DATA_W-1:0]));

    p_zero_eq_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_zero && b_zero && pred == 3'd0) |=> (&res_out[DATA_W-1:0]));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && res_valid) |=> $stable(res_out));

endmodule

bind fp64_pred_cmp fp64_pred_cmp_chk #(
    .DATA_W (DATA_W),
    .EXP_W  (EXP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dst_in    (dst_in),
    .src_in    (src_in),
    .pred      (pred),
    .res_out   (res_out),
    .res_valid (res_valid)
);

// File: tb/fp64_pred_cmp_tb.sv
module fp64_pred_cmp_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] dst_in = '0;
    logic [63:0]  src_in = '0;
    logic [2:0]   pred = '0;
    logic [127:0] res_out;
    logic         res_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    fp64_pred_cmp u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .dst_in    (dst_in),
        .src_in    (src_in),
        .pred      (pred),
        .res_out   (res_out),
        .res_valid (res_valid)
    );

    localparam logic [63:0] PZERO = 64'h0000000000000000;
    localparam logic [63:0] NZERO = 64'h8000000000000000;
    localparam logic [63:0] PINF  = 64'h7FF0000000000000;
    localparam logic [63:0] NINF  = 64'hFFF0000000000000;
    localparam logic [63:0] QNAN  = 64'h7FF8000000000001;
    localparam logic [63:0] SNAN  = 64'hFFF0000000000005;
    localparam logic [63:0] ONE   = 64'h3FF0000000000000;
    localparam logic [63:0] TWO   = 64'h4000000000000000;
    localparam logic [63:0] MONE  = 64'hBFF0000000000000;
    localparam logic [63:0] MTWO  = 64'hC000000000000000;

    function automatic bit is_nan(logic [63:0] v);
        return (&v[62:52]) && (|v[51:0]);
    endfunction

    function automatic bit ref_hit(logic [63:0] a, logic [63:0] b, int p);
        bit  un = is_nan(a) || is_nan(b);
        real ra = $bitstoreal(a);
        real rb = $bitstoreal(b);
        bit  e  = !un && (ra == rb);
        bit  l  = !un && (ra < rb);
        case (p)
            0: return e;
            1: return l;
            2: return l || e;
            3: return un;
            4: return !e;
            5: return !l;
            6: return !(l || e);
            default: return !un;
        endcase
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobe; checks result after the capturing edge and hold afterwards.
    task automatic apply(string req, logic [127:0] d, logic [63:0] s, int p);
        logic [127:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        dst_in   = d;
        src_in   = s;
        pred     = 3'(p);
        exp = {d[127:64], {64{ref_hit(d[63:0], s, p)}}};
        @(negedge clk);
        in_valid = 1'b0;
        dst_in   = {$urandom, $urandom, $urandom, $urandom};
        src_in   = {$urandom, $urandom};
        pred     = 3'($urandom);
        check({req, " R9 valid"}, {127'b0, res_valid}, 128'd1);
        check(req, res_out, exp);
        @(negedge clk);
        check("R9 valid drop", {127'b0, res_valid}, 128'd0);
        check("R11 hold", res_out, exp);
    endtask

    function automatic logic [63:0] pick();
        int r = int'($urandom % 10);
        case (r)
            0: return PZERO;
            1: return NZERO;
            2: return PINF;
            3: return NINF;
            4: return {$urandom[0], 11'h7FF, 1'b1, 19'($urandom), $urandom};
            5: return {$urandom[0], 11'h7FF, 1'b0, 19'($urandom), ($urandom | 32'd1)};
            6: return {$urandom, $urandom};
            7: return {$urandom[0], 11'h3FF, 20'($urandom % 4), 32'd0};
            default: return {$urandom[0], 11'(($urandom % 2046) + 1), 20'($urandom), $urandom};
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        check("R10 reset valid", {127'b0, res_valid}, 128'd0);
        check("R10 reset data", res_out, 128'd0);
        rst = 1'b0;

        // R1 R2: each predicate on an ordered and an unordered pair
        for (int p = 0; p < 8; p++) begin
            apply("R1 R2 ordered", {64'hA5A5_0000_1111_2222, ONE}, TWO, p);
            apply("R1 R5 unordered", {64'h0123_4567_89AB_CDEF, QNAN}, ONE, p);
            apply("R5 signalling NaN", {64'h0, ONE}, SNAN, p);
        end
        // R6 signed zeros
        apply("R6 -0 eq +0", {64'h0, NZERO}, PZERO, 0);
        apply("R6 -0 not lt +0", {64'h0, NZERO}, PZERO, 1);
        apply("R6 +0 not lt -0", {64'h0, PZERO}, NZERO, 1);
        apply("R6 +0 le -0", {64'h0, PZERO}, NZERO, 2);
        // R7 ordering
        apply("R7 neg below pos", {64'h0, MONE}, ONE, 1);
        apply("R7 larger neg smaller", {64'h0, MTWO}, MONE, 1);
        apply("R7 smaller neg not lt", {64'h0, MONE}, MTWO, 1);
        apply("R7 ninf lt", {64'h0, NINF}, MTWO, 1);
        apply("R7 pinf nlt", {64'h0, PINF}, TWO, 5);
        apply("R7 inf eq inf", {64'h0, PINF}, PINF, 0);
        // R8 greater-than by swap: is 2 > 1 ?
        apply("R8 swap gt true", {64'h0, ONE}, TWO, 1);
        apply("R8 swap gt false", {64'h0, TWO}, ONE, 1);
        // R3 R4: upper half passes, does not affect mask
        apply("R3 R4 upper A", {64'hFFFF_FFFF_FFFF_FFFF, MONE}, ONE, 1);
        apply("R3 R4 upper B", {64'h0000_0000_0000_0000, MONE}, ONE, 1);

        // back-to-back strobes
        @(negedge clk);
        in_valid = 1'b1; dst_in = {64'h1, ONE}; src_in = ONE; pred = 3'd0;
        @(negedge clk);
        check("R9 b2b first", res_out, {64'h1, {64{1'b1}}});
        dst_in = {64'h2, ONE}; src_in = TWO; pred = 3'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 b2b second", res_out, {64'h2, 64'h0});
        check("R9 b2b valid", {127'b0, res_valid}, 128'd1);

        // R10 reset overrides strobe
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1; dst_in = {64'h3, ONE}; src_in = ONE; pred = 3'd0;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check("R10 reset over strobe valid", {127'b0, res_valid}, 128'd0);
        check("R10 reset over strobe data", res_out, 128'd0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a = pick();
            logic [63:0] b = pick();
            int sel = int'($urandom % 4);
            if (sel == 0) b = a;
            else if (sel == 1) b = {~a[63], a[62:0]};
            apply("R1 R5 R7 random", {$urandom, $urandom, a}, b, int'($urandom % 8));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule